// File: doc/BRIEF.md
# Three-Buffer CAN Transmit Scheduler

This block decides which of three message buffers may send next on a CAN node. Software places a message in a buffer and locks it. The write to the buffer's final data byte arrives here as a strobe and marks the buffer pending. When the bus is idle, the scheduler picks the pending buffer with the highest fixed priority and hands its index to the frame transmitter with a one-cycle start pulse. While that frame is on the wire, the buffer's busy bit is held.

The transmitter reports each attempt as success, lost arbitration or error. A success ends the job. A failure either leaves the job pending, so it is tried again at the next idle bus, or ends it when the no-retransmit control is set. Unlocking a buffer or entering bus-off cancels pending work. A buffer of higher priority that becomes pending during an attempt goes first at the next idle bus. The pre-empted lower buffer stays pending and follows afterwards. Sticky done and error flags, gated by enables, drive a registered interrupt line.

Top module: `tx_sched`

## Requirements
- R1: After reset, all of ready_o, busy_o, tx_start_o, tx_idx_o, done_flag_o, err_flag_o and irq_o are zero.
- R2: A submit_i strobe on a buffer whose lock_i bit is high (and with bus_off_i low) sets that buffer's ready_o bit on the next clock edge. A strobe on an unlocked buffer leaves ready_o at zero.
- R3: Launch happens when the scheduler is idle, bus_idle_i is high and some buffer is ready, locked and not in bus-off. On the next cycle tx_start_o pulses for one cycle and tx_idx_o holds the highest ready index: index 2 beats 1, and 1 beats 0. tx_idx_o holds its value between launches.
- R4: The chosen buffer's busy_o bit rises with tx_start_o and falls on the edge that samples tx_done_i. At most one busy bit is ever high.
- R5: tx_result_i is coded 2'b00 = success, 2'b01 = lost arbitration and 2'b10 = error; any other value counts as an error. A success clears the buffer's ready bit and sets done_flag_o.
- R6: A failed attempt sets err_flag_o. With no_retx_i low, the buffer stays ready and is launched again at the next idle bus.
- R7: A failed attempt while no_retx_i is high clears the buffer's ready bit, so no further attempt follows.
- R8: Driving a buffer's lock_i low clears its ready bit on the next edge. bus_off_i high clears every ready bit, blocks new submissions and prevents any launch.
- R9: A higher-priority buffer that becomes ready during a lower buffer's attempt is launched first once that attempt ends. The lower buffer, if still ready, is launched afterwards.
- R10: No launch occurs while an attempt is in progress. tx_start_o is never high while busy_o was non-zero on the previous cycle.
- R11: The flags are sticky. flag_clr_i[0] clears done_flag_o and flag_clr_i[1] clears err_flag_o. A set in the same cycle wins over a clear.
- R12: irq_o is registered. After each edge it equals (done_flag_o AND the done_en_i sampled at that edge) OR (err_flag_o AND the sampled err_en_i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | NBUF | Lock state of each buffer |
| submit_i | input | NBUF | Write strobe to each buffer's final data byte |
| no_retx_i | input | 1 | Suppress automatic retries |
| bus_off_i | input | 1 | Node is in bus-off |
| bus_idle_i | input | 1 | Bus is idle and a frame may start |
| tx_done_i | input | 1 | Transmitter reports the end of an attempt |
| tx_result_i | input | 2 | Outcome of the attempt |
| done_en_i | input | 1 | Interrupt enable for the done flag |
| err_en_i | input | 1 | Interrupt enable for the error flag |
| flag_clr_i | input | 2 | Write-one-to-clear strobe: bit 0 done, bit 1 error |
| tx_start_o | output | 1 | One-cycle launch pulse to the transmitter |
| tx_idx_o | output | IDXW | Index of the launched buffer |
| ready_o | output | NBUF | Pending job per buffer |
| busy_o | output | NBUF | Attempt in progress per buffer |
| done_flag_o | output | 1 | Sticky transmit-done flag |
| err_flag_o | output | 1 | Sticky transmit-error flag |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the transmitter raises tx_done_i only during an attempt, and for one cycle per attempt. They also assume it holds bus_idle_i low from the start pulse until the attempt ends. The bench's transmitter model enforces both. It takes a fixed few cycles per attempt, draws each outcome from a queue that defaults to success, and derives bus_idle_i from its own activity. Every other input is free to change on any cycle. A behavioural model in the bench predicts every output on every clock, including the cycles where unlock, bus-off and submission collide.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;

  typedef enum logic [1:0] {
    RES_OK   = 2'b00,
    RES_ARB  = 2'b01,
    RES_ERR  = 2'b10
  } tx_res_e;

  typedef enum logic {
    SCH_IDLE   = 1'b0,
    SCH_ACTIVE = 1'b1
  } sch_state_e;

endpackage

// File: rtl/tx_prio_pick.sv
module tx_prio_pick #(
  parameter int N = 3,
  parameter int W = 2
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);

  // Higher index wins: later iterations overwrite earlier ones.
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end

endmodule

// File: rtl/tx_buf_slot.sv
module tx_buf_slot (
  input  logic clk,
  input  logic rst,
  input  logic lock_i,
  input  logic submit_i,
  input  logic bus_off_i,
  input  logic end_i,
  input  logic start_i,
  input  logic fin_i,
  output logic ready_o,
  output logic busy_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_o <= 1'b0;
    end else if (bus_off_i || !lock_i) begin
      ready_o <= 1'b0;
    end else if (submit_i) begin
      ready_o <= 1'b1;
    end else if (end_i) begin
      ready_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
    end else if (start_i) begin
      busy_o <= 1'b1;
    end else if (fin_i) begin
      busy_o <= 1'b0;
    end
  end

endmodule

// File: rtl/tx_evt_flags.sv
module tx_evt_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       ok_ev_i,
  input  logic       fail_ev_i,
  input  logic [1:0] clr_i,
  input  logic       done_en_i,
  input  logic       err_en_i,
  output logic       done_q_o,
  output logic       err_q_o,
  output logic       irq_q_o
);

  logic done_n, err_n;

  always_comb begin
    done_n = done_q_o;
    err_n  = err_q_o;
    if (clr_i[0]) done_n = 1'b0;
    if (clr_i[1]) err_n  = 1'b0;
    if (ok_ev_i)   done_n = 1'b1;
    if (fail_ev_i) err_n  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q_o <= 1'b0;
      err_q_o  <= 1'b0;
      irq_q_o  <= 1'b0;
    end else begin
      done_q_o <= done_n;
      err_q_o  <= err_n;
      irq_q_o  <= (done_n && done_en_i) || (err_n && err_en_i);
    end
  end

endmodule

// File: rtl/tx_sched.sv
module tx_sched
  import tx_sched_pkg::*;
#(
  parameter int NBUF = 3,
  localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NBUF-1:0] lock_i,
  input  logic [NBUF-1:0] submit_i,
  input  logic            no_retx_i,
  input  logic            bus_off_i,
  input  logic            bus_idle_i,
  input  logic            tx_done_i,
  input  logic [1:0]      tx_result_i,
  input  logic            done_en_i,
  input  logic            err_en_i,
  input  logic [1:0]      flag_clr_i,
  output logic            tx_start_o,
  output logic [IDXW-1:0] tx_idx_o,
  output logic [NBUF-1:0] ready_o,
  output logic [NBUF-1:0] busy_o,
  output logic            done_flag_o,
  output logic            err_flag_o,
  output logic            irq_o
);

  sch_state_e      state_q;
  logic [NBUF-1:0] cand;
  logic            cand_any;
  logic [IDXW-1:0] cand_idx;
  logic            launch;
  logic            done_ev;
  logic            ok_ev;
  logic            fail_ev;

  assign cand    = ready_o & lock_i & {NBUF{~bus_off_i}};
  assign launch  = (state_q == SCH_IDLE) && bus_idle_i && cand_any;
  assign done_ev = (state_q == SCH_ACTIVE) && tx_done_i;
  assign ok_ev   = done_ev && (tx_res_e'(tx_result_i) == RES_OK);
  assign fail_ev = done_ev && (tx_res_e'(tx_result_i) != RES_OK);

  tx_prio_pick #(.N(NBUF), .W(IDXW)) u_pick (
    .req_i (cand),
    .any_o (cand_any),
    .idx_o (cand_idx)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_slot
    logic mine;
    assign mine = (tx_idx_o == IDXW'(g));
    tx_buf_slot u_slot (
      .clk       (clk),
      .rst       (rst),
      .lock_i    (lock_i[g]),
      .submit_i  (submit_i[g]),
      .bus_off_i (bus_off_i),
      .end_i     (done_ev && mine && (ok_ev || no_retx_i)),
      .start_i   (launch && (cand_idx == IDXW'(g))),
      .fin_i     (done_ev && mine),
      .ready_o   (ready_o[g]),
      .busy_o    (busy_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SCH_IDLE;
      tx_start_o <= 1'b0;
      tx_idx_o   <= '0;
    end else begin
      tx_start_o <= launch;
      if (launch) begin
        tx_idx_o <= cand_idx;
        state_q  <= SCH_ACTIVE;
      end else if (done_ev) begin
        state_q  <= SCH_IDLE;
      end
    end
  end

  tx_evt_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .ok_ev_i   (ok_ev),
    .fail_ev_i (fail_ev),
    .clr_i     (flag_clr_i),
    .done_en_i (done_en_i),
    .err_en_i  (err_en_i),
    .done_q_o  (done_flag_o),
    .err_q_o   (err_flag_o),
    .irq_q_o   (irq_o)
  );

endmodule

// File: rtl/tx_sched_chk.sv
module tx_sched_chk #(
  parameter int NBUF = 3,
  localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic [NBUF-1:0] lock_i,
  input logic [NBUF-1:0] submit_i,
  input logic            no_retx_i,
  input logic            bus_off_i,
  input logic            bus_idle_i,
  input logic            tx_done_i,
  input logic [1:0]      tx_result_i,
  input logic            done_en_i,
  input logic            err_en_i,
  input logic [1:0]      flag_clr_i,
  input logic            tx_start_o,
  input logic [IDXW-1:0] tx_idx_o,
  input logic [NBUF-1:0] ready_o,
  input logic [NBUF-1:0] busy_o,
  input logic            done_flag_o,
  input logic            err_flag_o,
  input logic            irq_o
);

  logic [NBUF-1:0] elig;
  assign elig = ready_o & lock_i & {NBUF{~bus_off_i}};

  // R4
  one_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(busy_o));

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start_o |-> busy_o[tx_idx_o]);

  // R3
  prio_pick_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start_o |-> (($past(elig) >> tx_idx_o) == NBUF'(1)));

  // R10
  no_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start_o |-> ($past(busy_o) == '0));

  // R8
  bus_off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    bus_off_i |=> (ready_o == '0));

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done_flag_o && !flag_clr_i[0]) |=> done_flag_o);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flag_o && !flag_clr_i[1]) |=> err_flag_o);

  // R5
  ok_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ((busy_o != '0) && tx_done_i && (tx_result_i == 2'b00)) |=> done_flag_o);

  for (genvar g = 0; g < NBUF; g++) begin : g_bit
    // R2
    submit_set_chk: assert property (@(posedge clk) disable iff (rst)
      (submit_i[g] && lock_i[g] && !bus_off_i) |=> ready_o[g]);
    // R8
    unlock_clear_chk: assert property (@(posedge clk) disable iff (rst)
      !lock_i[g] |=> !ready_o[g]);
  end

endmodule

bind tx_sched tx_sched_chk #(.NBUF(NBUF)) u_chk (.*);

// File: tb/tb_tx_sched.sv
module tb_tx_sched;
  localparam int NB = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NB-1:0] lock_i = '0, submit_i = '0;
  logic no_retx_i = 0, bus_off_i = 0, bus_idle_i = 0, tx_done_i = 0;
  logic [1:0] tx_result_i = 2'b00, flag_clr_i = 2'b00;
  logic done_en_i = 0, err_en_i = 0;
  logic tx_start_o, done_flag_o, err_flag_o, irq_o;
  logic [IW-1:0] tx_idx_o;
  logic [NB-1:0] ready_o, busy_o;

  always #4 clk = ~clk;

  tx_sched #(.NBUF(NB)) dut (.*);

  int nchk = 0, nerr = 0;
  logic idle_en = 0;
  logic [1:0] res_q[$];
  int start_log[$];

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Transmitter model
  logic tx_act = 0;
  int cnt = 0;
  always @(negedge clk) begin
    if (rst) begin
      tx_act = 0; tx_done_i = 0; bus_idle_i = 0;
    end else begin
      tx_done_i = 0;
      if (tx_act) begin
        if (cnt == 0) begin
          tx_done_i = 1;
          tx_result_i = (res_q.size() > 0) ? res_q.pop_front() : 2'b00;
          tx_act = 0;
        end else cnt--;
      end
      if (tx_start_o) begin
        tx_act = 1; cnt = 2;
        start_log.push_back(int'(tx_idx_o));
      end
      bus_idle_i = idle_en && !tx_act && !tx_done_i;
    end
  end

  // Behavioural reference model
  logic [NB-1:0] m_rdy = '0, m_bsy = '0;
  logic m_start = 0, m_act = 0, m_d = 0, m_e = 0, m_irq = 0;
  int m_idx = 0;
  always @(posedge clk) begin
    int pick;
    bit go, fin;
    if (rst) begin
      m_rdy = '0; m_bsy = '0; m_start = 0; m_act = 0;
      m_d = 0; m_e = 0; m_irq = 0; m_idx = 0;
    end else begin
      pick = -1;
      for (int i = 0; i < NB; i++)
        if (m_rdy[i] && lock_i[i] && !bus_off_i) pick = i;
      go  = !m_act && bus_idle_i && (pick >= 0);
      fin = m_act && tx_done_i;
      for (int i = 0; i < NB; i++) begin
        if (bus_off_i || !lock_i[i]) m_rdy[i] = 0;
        else if (submit_i[i]) m_rdy[i] = 1;
        else if (fin && m_idx == i && (tx_result_i == 2'b00 || no_retx_i)) m_rdy[i] = 0;
        if (go && pick == i) m_bsy[i] = 1;
        else if (fin && m_idx == i) m_bsy[i] = 0;
      end
      if (flag_clr_i[0]) m_d = 0;
      if (flag_clr_i[1]) m_e = 0;
      if (fin && tx_result_i == 2'b00) m_d = 1;
      if (fin && tx_result_i != 2'b00) m_e = 1;
      m_irq = (m_d && done_en_i) || (m_e && err_en_i);
      m_start = go;
      if (go) begin m_idx = pick; m_act = 1; end
      else if (fin) m_act = 0;
    end
  end

  // Per-clock comparison and launch-while-busy monitor
  logic [NB-1:0] prev_busy = '0;
  int busy_launch = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 ready_o", int'(ready_o), int'(m_rdy));
      chk("R4 busy_o", int'(busy_o), int'(m_bsy));
      chk("R3 tx_start_o", int'(tx_start_o), int'(m_start));
      chk("R3 tx_idx_o", int'(tx_idx_o), m_idx);
      chk("R5 done_flag_o", int'(done_flag_o), int'(m_d));
      chk("R6 err_flag_o", int'(err_flag_o), int'(m_e));
      chk("R12 irq_o", int'(irq_o), int'(m_irq));
      if (tx_start_o && prev_busy != '0) busy_launch++;
    end
    prev_busy = busy_o;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_submit(input logic [NB-1:0] m);
    @(negedge clk); submit_i = m;
    @(negedge clk); submit_i = '0;
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr_i = 2'b11;
    @(negedge clk); flag_clr_i = 2'b00;
  endtask

  bit fin_run = 0;
  initial begin
    cyc(4);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset ready", int'(ready_o), 0);
    chk("R1 reset busy", int'(busy_o), 0);
    chk("R1 reset flags", int'({done_flag_o, err_flag_o, irq_o, tx_start_o}), 0);

    done_en_i = 1; err_en_i = 1;
    // R2: unlocked buffer ignores the strobe
    lock_i = 3'b011;
    pulse_submit(3'b100);
    chk("R2 unlocked submit ignored", int'(ready_o), 0);
    pulse_submit(3'b011);
    chk("R2 locked submit", int'(ready_o), 3);

    // R3/R5: priority and success
    start_log.delete();
    idle_en = 1;
    cyc(20);
    chk("R3 launch count", start_log.size(), 2);
    if (start_log.size() == 2) begin
      chk("R3 first launch is index 1", start_log[0], 1);
      chk("R3 second launch is index 0", start_log[1], 0);
    end
    chk("R5 ready cleared by success", int'(ready_o), 0);
    chk("R5 done flag set", int'(done_flag_o), 1);
    cyc(3);
    chk("R11 done flag sticky", int'(done_flag_o), 1);
    clear_flags();
    chk("R11 flags cleared", int'({done_flag_o, err_flag_o}), 0);

    // R6: retry after lost arbitration
    lock_i = 3'b111;
    start_log.delete();
    res_q.push_back(2'b01);
    pulse_submit(3'b001);
    cyc(20);
    chk("R6 retry launch count", start_log.size(), 2);
    chk("R6 error flag", int'(err_flag_o), 1);
    chk("R6 done after retry", int'(done_flag_o), 1);
    clear_flags();

    // R7: no-retransmit ends the job on error
    no_retx_i = 1;
    start_log.delete();
    res_q.push_back(2'b10);
    pulse_submit(3'b010);
    cyc(15);
    chk("R7 single attempt", start_log.size(), 1);
    chk("R7 ready cleared", int'(ready_o), 0);
    chk("R7 error flag", int'(err_flag_o), 1);
    chk("R7 no done flag", int'(done_flag_o), 0);
    // R12: enables gate the interrupt
    err_en_i = 0;
    cyc(2);
    chk("R12 irq masked", int'(irq_o), 0);
    err_en_i = 1;
    cyc(2);
    chk("R12 irq unmasked", int'(irq_o), 1);
    clear_flags();
    no_retx_i = 0;

    // R9: pre-emption by a higher buffer during an attempt
    start_log.delete();
    res_q.push_back(2'b10);
    pulse_submit(3'b001);
    cyc(1);
    chk("R4 busy during attempt", int'(busy_o), 1);
    pulse_submit(3'b100);
    cyc(25);
    chk("R9 launch count", start_log.size(), 3);
    if (start_log.size() == 3) begin
      chk("R9 order first", start_log[0], 0);
      chk("R9 higher goes next", start_log[1], 2);
      chk("R9 lower resumes", start_log[2], 0);
    end
    chk("R9 all served", int'(ready_o), 0);
    clear_flags();

    // R8: unlock and bus-off cancel
    idle_en = 0;
    cyc(3);
    pulse_submit(3'b110);
    chk("R8 both pending", int'(ready_o), 6);
    @(negedge clk); lock_i = 3'b011;
    @(negedge clk);
    chk("R8 unlock clears", int'(ready_o), 2);
    bus_off_i = 1;
    @(negedge clk);
    chk("R8 bus-off clears", int'(ready_o), 0);
    pulse_submit(3'b011);
    chk("R8 submit blocked in bus-off", int'(ready_o), 0);
    idle_en = 1;
    cyc(5);
    chk("R8 no launch in bus-off", int'(busy_o), 0);
    bus_off_i = 0;
    idle_en = 0;

    // R10
    chk("R10 no launch while busy", busy_launch, 0);
    cyc(2);
    fin_run = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin_run) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule